// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block picks the way of a cache set that should be evicted on a miss. It holds replacement state for every set of an N-way structure and follows one of three policies, fixed by a parameter: least-recently-used, first-in-first-out, or a reproducible pseudorandom choice. The block stores no tags and no data. It only records accesses and names a victim.

A cache controller reports each hit or fill with an access strobe, the set and the way involved, and a bit that marks fills. When it needs to evict, it raises the victim request, gives the set, and supplies the valid bits of that set's ways. The victim way number is combinational from the present state. A way that is not valid is always chosen ahead of the policy's choice. State changes on the clock edge after an access.

Top module: `way_victim_select`

## Requirements
- R1: If any bit of `way_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0, whatever the policy.
- R2: In LRU mode with all ways valid, `victim_way` is the way of the requested set that has gone longest without a hit or a fill. Both hits and fills count as use.
- R3: After reset, every set ranks its ways so that way 0 is evicted first, then way 1, and so on in increasing order. With all ways valid, the first victim of any set is way 0 in both LRU and FIFO modes.
- R4: In FIFO mode with all ways valid, the victim is the way whose most recent fill is the oldest. Hits (`acc_fill`=0) leave the order unchanged.
- R5: In random mode with all ways valid, `victim_way` is the current 16-bit LFSR value modulo the way count. The LFSR resets to 0xACE1. On each cycle with `vic_req` high it shifts left by one bit and enters bit15^bit13^bit12^bit10 at bit 0.
- R6: With a single way, `victim_way` is always 0.
- R7: When an access and a victim request occur in the same cycle, the victim reflects the state before that access.
- R8: An access to one set does not change the victim choice of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A hit or a fill happens this cycle |
| acc_fill | input | 1 | 1 marks the access as a fill, 0 as a hit |
| acc_set | input | SET_W | Set touched by the access |
| acc_way | input | WAY_W | Way touched by the access |
| vic_req | input | 1 | Victim requested this cycle |
| vic_set | input | SET_W | Set whose victim is wanted |
| way_valid | input | NUM_WAYS | Valid bits of the ways in `vic_set` |
| victim_way | output | WAY_W | Chosen way |

## Verification
The bench builds four copies with 8 sets: an LRU copy, a FIFO copy and a random copy with 4 ways, and a copy with 1 way. All four take the same stimulus. Eight sets give frequent revisits under random set choice, so long recency and fill histories form in each set and the rankings of different sets drift apart. Four ways exercise moves from every list position. The single-way copy covers the direct-mapped case.

// File: rtl/wvs_pkg.sv
// Shared definitions for the way replacement selector.
package wvs_pkg;
    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2
    } policy_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/wvs_order_list.sv
// Per-set ordered list of way numbers: entry 0 is the newest, and the last
// entry is the eviction candidate. An update moves a way to the front.
// Assumes NUM_SETS is a power of two and upd_way < NUM_WAYS.
module wvs_order_list #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] tail_way
);
    logic [WAY_W-1:0] ord_q [NUM_SETS][NUM_WAYS];
    logic [WAY_W-1:0] row_cur [NUM_WAYS];
    logic [WAY_W-1:0] row_nxt [NUM_WAYS];

    // Build the reordered row for the updated set.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < NUM_WAYS; k++) row_cur[k] = ord_q[upd_set][k];
        row_nxt[0] = upd_way;
        for (int k = 1; k < NUM_WAYS; k++) begin
            seen       = seen | (row_cur[k-1] == upd_way);
            row_nxt[k] = seen ? row_cur[k] : row_cur[k-1];
        end
    end

    // Hold the lists: reset ranks way 0 last, and an update writes one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int k = 0; k < NUM_WAYS; k++)
                    ord_q[s][k] <= WAY_W'(NUM_WAYS - 1 - k);
        end else if (upd_en) begin
            for (int k = 0; k < NUM_WAYS; k++)
                ord_q[upd_set][k] <= row_nxt[k];
        end
    end

    // Present the candidate of the requested set.
    assign tail_way = ord_q[rd_set][NUM_WAYS-1];
endmodule

// File: rtl/wvs_lfsr.sv
// 16-bit maximal-length Fibonacci LFSR with a fixed seed. It steps once
// for each cycle in which step is high.
module wvs_lfsr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] value
);
    logic [15:0] lfsr_q;

    // Advance the generator on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)    lfsr_q <= wvs_pkg::LFSR_SEED;
        else if (step) lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    assign value = lfsr_q;
endmodule

// File: rtl/wvs_invalid_pick.sv
// Finds the lowest-numbered invalid way. Purely combinational.
module wvs_invalid_pick #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] valid,
    output logic                any_free,
    output logic [WAY_W-1:0]    free_way
);
    // Scan from the top down so that the lowest invalid index wins.
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/way_victim_select.sv
// Replacement selector for an N-way set-associative structure. POLICY picks
// LRU, FIFO or pseudorandom selection. An invalid way always wins.
// The victim is combinational from the current state. Accesses update the
// state on the next clock edge.
module way_victim_select #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter wvs_pkg::policy_e POLICY = wvs_pkg::POL_LRU,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_fill,
    input  logic [SET_W-1:0]    acc_set,
    input  logic [WAY_W-1:0]    acc_way,
    input  logic                vic_req,
    input  logic [SET_W-1:0]    vic_set,
    input  logic [NUM_WAYS-1:0] way_valid,
    output logic [WAY_W-1:0]    victim_way
);
    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] policy_way;

    wvs_invalid_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .valid(way_valid), .any_free(any_free), .free_way(free_way)
    );

    generate
        if (NUM_WAYS == 1) begin : g_direct
            logic unused_dm;
            assign unused_dm  = ^{clk, rst_n, acc_valid, acc_fill, acc_set, acc_way, vic_req, vic_set};
            assign policy_way = '0;
        end else if (POLICY == wvs_pkg::POL_RAND) begin : g_rand
            logic [15:0] lfsr_val;
            logic [15:0] lfsr_mod;
            logic        unused_rand;
            wvs_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .step(vic_req), .value(lfsr_val));
            assign lfsr_mod    = lfsr_val % 16'(NUM_WAYS);
            assign policy_way  = lfsr_mod[WAY_W-1:0];
            assign unused_rand = ^{acc_valid, acc_fill, acc_set, acc_way, vic_set, lfsr_mod[15:WAY_W]};
        end else begin : g_list
            logic upd_en;
            // LRU reorders on every access; FIFO reorders on fills only.
            assign upd_en = acc_valid && ((POLICY == wvs_pkg::POL_LRU) || acc_fill);
            wvs_order_list #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_list (
                .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_set(acc_set),
                .upd_way(acc_way), .rd_set(vic_set), .tail_way(policy_way)
            );
            logic unused_list;
            assign unused_list = vic_req;
        end
    endgenerate

    // An invalid way takes priority over the policy choice.
    assign victim_way = any_free ? free_way : policy_way;
endmodule

// File: rtl/wvs_checker.sv
// Property checks for way_victim_select, attached with bind.
module wvs_checker #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter wvs_pkg::policy_e POLICY = wvs_pkg::POL_LRU,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic                acc_fill,
    input logic [SET_W-1:0]    acc_set,
    input logic [WAY_W-1:0]    acc_way,
    input logic [SET_W-1:0]    vic_set,
    input logic [NUM_WAYS-1:0] way_valid,
    input logic [WAY_W-1:0]    victim_way
);
    localparam bit LIST_MODE = (NUM_WAYS > 1) && (POLICY != wvs_pkg::POL_RAND);

    // R1: an invalid way is picked whenever one exists.
    a_r1_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        !(&way_valid) |-> !way_valid[victim_way]);

    // R1: the pick is the lowest invalid way.
    a_r1_lowest_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&way_valid) && victim_way != 0) |-> way_valid[0]);

    // R2/R4: a way just used (LRU) or just filled (FIFO) is not the next victim of its set.
    a_r2_recent_spared: assert property (@(posedge clk) disable iff (!rst_n)
        (LIST_MODE && acc_valid && (POLICY == wvs_pkg::POL_LRU || acc_fill))
        |=> (vic_set != $past(acc_set) || !(&way_valid) || victim_way != $past(acc_way)));

    // R6: a single-way build always names way 0.
    a_r6_direct_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_WAYS == 1) |-> victim_way == '0);

    // Victim index stays inside the way range.
    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(victim_way) < NUM_WAYS);
endmodule

bind way_victim_select wvs_checker #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .POLICY(POLICY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill),
    .acc_set(acc_set), .acc_way(acc_way), .vic_set(vic_set),
    .way_valid(way_valid), .victim_way(victim_way)
);

// File: tb/way_victim_select_bench.sv
module way_victim_select_bench;
    localparam int SETS = 8;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_fill = 1'b0, vic_req = 1'b0;
    logic [2:0] acc_set = '0, vic_set = '0;
    logic [1:0] acc_way = '0;
    logic [3:0] way_valid = '1;
    logic [1:0] v_lru, v_fifo, v_rand;
    logic       v_dm;

    int total = 0, bad = 0;
    int lru_m [SETS][WAYS];
    int fifo_m [SETS][WAYS];
    logic [15:0] lfsr_m;

    always #10 clk = ~clk;

    way_victim_select #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(wvs_pkg::POL_LRU)) u_way_victim_select (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_set(acc_set),
        .acc_way(acc_way), .vic_req(vic_req), .vic_set(vic_set), .way_valid(way_valid), .victim_way(v_lru));
    way_victim_select #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(wvs_pkg::POL_FIFO)) u_way_victim_select_fifo (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_set(acc_set),
        .acc_way(acc_way), .vic_req(vic_req), .vic_set(vic_set), .way_valid(way_valid), .victim_way(v_fifo));
    way_victim_select #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .POLICY(wvs_pkg::POL_RAND)) u_way_victim_select_rand (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_set(acc_set),
        .acc_way(acc_way), .vic_req(vic_req), .vic_set(vic_set), .way_valid(way_valid), .victim_way(v_rand));
    way_victim_select #(.NUM_SETS(SETS), .NUM_WAYS(1), .POLICY(wvs_pkg::POL_LRU)) u_way_victim_select_dm (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_set(acc_set),
        .acc_way(1'b0), .vic_req(vic_req), .vic_set(vic_set), .way_valid(way_valid[0]), .victim_way(v_dm));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: lowest invalid way, or -1 when all are valid (R1).
    function automatic int free_ref(input logic [3:0] v);
        for (int w = 0; w < WAYS; w++) if (!v[w]) return w;
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int k = 0; k < WAYS; k++) begin
                lru_m[s][k]  = WAYS - 1 - k;
                fifo_m[s][k] = WAYS - 1 - k;
            end
        lfsr_m = 16'hACE1;
    endtask

    task automatic move_front(input bit fifo, input int s, input int w);
        int p = 0;
        for (int k = 0; k < WAYS; k++) if ((fifo ? fifo_m[s][k] : lru_m[s][k]) == w) p = k;
        for (int k = p; k > 0; k--)
            if (fifo) fifo_m[s][k] = fifo_m[s][k-1]; else lru_m[s][k] = lru_m[s][k-1];
        if (fifo) fifo_m[s][0] = w; else lru_m[s][0] = w;
    endtask

    // Compare all four outputs mid-cycle, then apply the edge to the model.
    task automatic step_check();
        int f;
        #5;
        f = free_ref(way_valid);
        check(f >= 0 ? "R1 lru" : "R2 lru", v_lru, f >= 0 ? f : lru_m[vic_set][WAYS-1]);
        check(f >= 0 ? "R1 fifo" : "R4 fifo", v_fifo, f >= 0 ? f : fifo_m[vic_set][WAYS-1]);
        check(f >= 0 ? "R1 rand" : "R5 rand", v_rand, f >= 0 ? f : int'(lfsr_m % 16'(WAYS)));
        check(way_valid[0] ? "R6 dm" : "R1 dm", v_dm, 0);
        @(posedge clk); #1;
        if (acc_valid) begin
            move_front(1'b0, acc_set, acc_way);
            if (acc_fill) move_front(1'b1, acc_set, acc_way);
        end
        if (vic_req) lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    endtask

    task automatic drive(input bit av, input bit af, input int as, input int aw,
                         input bit vr, input int vs, input logic [3:0] vv);
        @(negedge clk);
        acc_valid = av; acc_fill = af; acc_set = 3'(as); acc_way = 2'(aw);
        vic_req = vr; vic_set = 3'(vs); way_valid = vv;
        step_check();
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R3: after reset every set evicts way 0 first in LRU and FIFO modes.
        for (int s = 0; s < SETS; s++) drive(0, 0, 0, 0, 0, s, 4'hF);
        // R1: invalid ways override the policy.
        drive(0, 0, 0, 0, 1, 3, 4'b1011);
        drive(0, 0, 0, 0, 1, 3, 4'b0110);
        // R4: a hit to way 0 leaves FIFO victim 0; LRU moves to way 1 (R2).
        drive(1, 0, 5, 0, 0, 5, 4'hF);
        drive(0, 0, 0, 0, 0, 5, 4'hF);
        // R7: access and request in one cycle: the victim is from the old state.
        drive(1, 1, 5, 1, 1, 5, 4'hF);
        check("R7 same cycle later", v_lru, 2);
        // R8: set 5 activity leaves set 6 at way 0.
        drive(0, 0, 0, 0, 0, 6, 4'hF);
        // R2/R4/R5/R8: random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] vv;
            vv = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
            drive($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, SETS - 1),
                  $urandom_range(0, WAYS - 1), $urandom_range(0, 1) == 1, $urandom_range(0, SETS - 1), vv);
        end
        // R3: a second reset restores the initial ranking and seed.
        @(negedge clk); rst_n = 1'b0; acc_valid = 0; vic_req = 0;
        @(posedge clk); #1; model_reset();
        @(negedge clk); rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 2, 4'hF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule